// File: doc/BRIEF.md
# Time-Protected Configuration Register

This block holds one 8-bit system configuration byte on a simple processor-style bus. Each bit drives a control signal: converter power, converter clock source, interrupt edge selection, start-up delay, two clock-monitor enables, and a two-bit rate select. Three bits (converter power, converter clock source, clock monitor) can be written at any time. The other five are protected. In normal mode those five take effect from a single write, and only if that write arrives within a fixed number of bus cycles after reset is released. After that they keep their value until the next reset. In special mode every bit can be written at any time.

A saturating cycle timer measures the window. A three-state lock machine decides whether the protected bits may change. The lock machine's states are `ST_OPEN`, `ST_SPENT` and `ST_EXPIRED`, and it has three transitions:

- `ST_OPEN` to `ST_SPENT` on a normal-mode write to the register.
- `ST_OPEN` to `ST_EXPIRED` in the last window cycle when no such write occurs.
- `ST_SPENT` and `ST_EXPIRED` hold until reset.

A bit bank merges each write according to the lock machine's permission.

Top module: `cfg_guard_reg`

## Requirements
- R1: While reset is asserted and after it is released, the register holds 0x10: only bit 4 is set.
- R2: The outputs always mirror the stored bits:
  - bit 7: `conv_pwr_en`
  - bit 6: `conv_clk_sel`
  - bit 5: `irq_edge_sel`
  - bit 4: `startup_dly_en`
  - bit 3: `clk_mon_en`
  - bit 2: `fast_mon_en`
  - bits 1:0: `rate_sel`
- R3: Bits 7, 6 and 3 are unprotected. They take the value of `wdata` on every write to address 0x39, in either mode and at any time.
- R4: Bits 5, 4, 2, 1 and 0 are protected. In normal mode (`special_mode` low) they take `wdata` from a write to 0x39 issued at a rising edge numbered 0 to 63, where edge 0 is the first rising edge with `rst_n` high.
- R5: After one normal-mode write has been accepted in the window, later normal-mode writes leave all protected bits unchanged until reset.
- R6: A normal-mode write at edge 64 or later changes only the unprotected bits. No error indication is produced.
- R7: With `special_mode` high, a write updates all eight bits at any time. Such a write does not use up the single normal-mode write.
- R8: `special_mode` is only sampled with each write. Toggling it without a write leaves every stored bit unchanged.
- R9: With `rd_en` high and `addr` equal to 0x39, `rdata` shows the stored byte in the same cycle. Otherwise `rdata` is 0x00.
- R10: A write to any address other than 0x39 changes no bit and does not close the once-only chance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Bus address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| special_mode | input | 1 | High selects special (unlocked) operation |
| rdata | output | 8 | Read data |
| conv_pwr_en | output | 1 | Converter power enable (bit 7) |
| conv_clk_sel | output | 1 | Converter clock source select (bit 6) |
| irq_edge_sel | output | 1 | Interrupt edge select (bit 5) |
| startup_dly_en | output | 1 | Start-up delay enable (bit 4) |
| clk_mon_en | output | 1 | Clock monitor enable (bit 3) |
| fast_mon_en | output | 1 | Fast clock monitor enable (bit 2) |
| rate_sel | output | 2 | Rate select (bits 1:0) |

## Verification
The bench writes the protected bits exactly at edge 63 and at edge 64. An off-by-one in the timer would either accept the late write or reject the last legal one. It issues a second normal-mode write after an accepted one, which a design missing the sticky lock would let through. It also writes in special mode before a normal write in the window, which a design that wrongly treats special writes as consuming the chance would reject. It toggles the mode with no write and sends writes to a neighbouring address, catching designs that update bits or burn the chance without a matching write.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    localparam int CFG_W = 8;

    // bit positions of the configuration fields
    localparam int BIT_PWR     = 7;
    localparam int BIT_CLKSEL  = 6;
    localparam int BIT_IRQEDGE = 5;
    localparam int BIT_DLY     = 4;
    localparam int BIT_CMON    = 3;
    localparam int BIT_FMON    = 2;
    localparam int BIT_RATE_HI = 1;
    localparam int BIT_RATE_LO = 0;

    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_SPENT   = 2'd1,
        ST_EXPIRED = 2'd2
    } lock_state_t;

endpackage

// File: rtl/cfg_window_timer.sv
module cfg_window_timer #(
    parameter int WINDOW_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_open,
    output logic win_last
);
    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(WINDOW_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WINDOW_CYCLES - 1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (count_q != CNT_MAX) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_comb begin
        win_open = (count_q < CNT_MAX);
        win_last = (count_q == CNT_LAST);
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> !win_open); // R6

endmodule

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
    import cfg_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic        special_mode,
    input  logic        win_open,
    input  logic        win_last,
    output logic        prot_ok,
    output lock_state_t state_o
);
    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (wr_hit && !special_mode) begin
                    state_d = ST_SPENT;
                end else if (win_last) begin
                    state_d = ST_EXPIRED;
                end
            end
            ST_SPENT:   state_d = ST_SPENT;
            ST_EXPIRED: state_d = ST_EXPIRED;
            default:    state_d = ST_EXPIRED;
        endcase
    end

    // outputs
    always_comb begin
        prot_ok = special_mode || (state_q == ST_OPEN);
        state_o = state_q;
    end

    AST_OPEN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |-> win_open); // R4

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OPEN) |=> (state_q == $past(state_q))); // R5

endmodule

// File: rtl/cfg_bits_bank.sv
module cfg_bits_bank
    import cfg_guard_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_VAL = 8'h10,
    parameter logic [CFG_W-1:0] PROT_MASK = 8'h37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             prot_ok,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q
);
    logic [CFG_W-1:0] keep_mask;

    always_comb begin
        keep_mask = prot_ok ? '0 : PROT_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RESET_VAL;
        end else if (wr_hit) begin
            cfg_q <= (cfg_q & keep_mask) | (wdata & ~keep_mask);
        end
    end

    AST_UNPROT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (((cfg_q ^ $past(wdata)) & ~PROT_MASK) == '0)); // R3

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_ok |=> $stable(cfg_q & PROT_MASK)); // R5

endmodule

// File: rtl/cfg_guard_reg.sv
module cfg_guard_reg
    import cfg_guard_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR      = 8'h39,
    parameter int                WINDOW_CYCLES = 64,
    parameter logic [CFG_W-1:0]  RESET_VAL     = 8'h10,
    parameter logic [CFG_W-1:0]  PROT_MASK     = 8'h37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              special_mode,
    output logic [CFG_W-1:0]  rdata,
    output logic              conv_pwr_en,
    output logic              conv_clk_sel,
    output logic              irq_edge_sel,
    output logic              startup_dly_en,
    output logic              clk_mon_en,
    output logic              fast_mon_en,
    output logic [1:0]        rate_sel
);
    logic             wr_hit;
    logic             rd_hit;
    logic             win_open;
    logic             win_last;
    logic             prot_ok;
    lock_state_t      lock_state;
    logic [CFG_W-1:0] cfg_q;

    always_comb begin
        wr_hit = wr_en && (addr == CFG_ADDR);
        rd_hit = rd_en && (addr == CFG_ADDR);
        rdata  = rd_hit ? cfg_q : '0;
    end

    cfg_window_timer #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_open(win_open),
        .win_last(win_last)
    );

    cfg_lock_fsm lock_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (wr_hit),
        .special_mode(special_mode),
        .win_open    (win_open),
        .win_last    (win_last),
        .prot_ok     (prot_ok),
        .state_o     (lock_state)
    );

    cfg_bits_bank #(
        .RESET_VAL(RESET_VAL),
        .PROT_MASK(PROT_MASK)
    ) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .prot_ok(prot_ok),
        .wdata  (wdata),
        .cfg_q  (cfg_q)
    );

    always_comb begin
        conv_pwr_en    = cfg_q[BIT_PWR];
        conv_clk_sel   = cfg_q[BIT_CLKSEL];
        irq_edge_sel   = cfg_q[BIT_IRQEDGE];
        startup_dly_en = cfg_q[BIT_DLY];
        clk_mon_en     = cfg_q[BIT_CMON];
        fast_mon_en    = cfg_q[BIT_FMON];
        rate_sel       = cfg_q[BIT_RATE_HI:BIT_RATE_LO];
    end

    AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr != CFG_ADDR)) |=> $stable(cfg_q)); // R10

    AST_SPENT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(lock_state) && (lock_state == ST_SPENT)
            |-> $past(wr_hit && !special_mode)); // R7

endmodule

// File: tb/cfg_guard_reg_tb_top.sv
module cfg_guard_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h39;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       special_mode = 1'b0;
    logic [7:0] rdata;
    logic       conv_pwr_en, conv_clk_sel, irq_edge_sel, startup_dly_en;
    logic       clk_mon_en, fast_mon_en;
    logic [1:0] rate_sel;

    int compared = 0;
    int mismatched = 0;
    int wd_cycles = 0;
    string phase = "R1";

    // reference model state
    logic [7:0] m_reg;
    bit         m_spent;
    int         m_cyc;
    bit         m_okp;
    bit         sp = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    cfg_guard_reg dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .special_mode(special_mode), .rdata(rdata),
        .conv_pwr_en(conv_pwr_en), .conv_clk_sel(conv_clk_sel),
        .irq_edge_sel(irq_edge_sel), .startup_dly_en(startup_dly_en),
        .clk_mon_en(clk_mon_en), .fast_mon_en(fast_mon_en), .rate_sel(rate_sel)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = 8'h10;
            m_spent = 1'b0;
            m_cyc = 0;
        end else begin
            if (wr_en && addr == 8'h39) begin
                m_okp = special_mode || (!m_spent && m_cyc < 64);
                m_reg[7] = wdata[7];
                m_reg[6] = wdata[6];
                m_reg[3] = wdata[3];
                if (m_okp) begin
                    m_reg[5] = wdata[5];
                    m_reg[4] = wdata[4];
                    m_reg[2] = wdata[2];
                    m_reg[1] = wdata[1];
                    m_reg[0] = wdata[0];
                end
                if (!special_mode && m_cyc < 64) m_spent = 1'b1;
            end
            if (m_cyc < 64) m_cyc++;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_now();
        logic [7:0] outs;
        outs = {conv_pwr_en, conv_clk_sel, irq_edge_sel, startup_dly_en,
                clk_mon_en, fast_mon_en, rate_sel};
        chk({"R2 field mirror during ", phase}, outs, m_reg);
        if (rd_en && addr == 8'h39) chk({phase, " read"}, rdata, m_reg);
        else chk("R9 idle rdata", rdata, 8'h00);
    endtask

    task automatic step(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        check_now();
        wr_en = w; rd_en = r; addr = a; wdata = d; special_mode = sp;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 8'h39, 8'h00);
    endtask

    task automatic wr(input logic [7:0] d);
        step(1'b1, 1'b1, 8'h39, d);
    endtask

    // after this returns, the next posedge is edge 0 with idle inputs
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b1; addr = 8'h39; sp = 1'b0; special_mode = 1'b0;
        idle(3);
        @(negedge clk);
        check_now();
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        phase = "R1";
        do_reset();
        idle(1);                                   // edge 1
        phase = "R10";
        step(1'b1, 1'b1, 8'h38, 8'hFF);            // edge 2, foreign address
        idle(2);
        phase = "R4";
        wr(8'h2F);                                 // accepted in window
        idle(2);
        phase = "R5";
        wr(8'hD0);                                 // protected part ignored
        idle(2);
        phase = "R3";
        wr(8'h08);
        idle(1);
        phase = "R7";
        sp = 1'b1;
        wr(8'h00);
        idle(1);
        wr(8'h15);
        idle(1);
        phase = "R8";
        sp = 1'b0;
        idle(3);
        wr(8'hFF);
        idle(60);
        phase = "R6";
        wr(8'h00);
        idle(2);
        sp = 1'b1;
        phase = "R7 late special";
        wr(8'h37);
        idle(2);
        sp = 1'b0;

        // boundary: last legal edge 63
        phase = "R1";
        do_reset();
        phase = "R4 edge 63";
        idle(62);
        wr(8'h27);
        idle(3);

        // boundary: edge 64 is too late
        phase = "R1";
        do_reset();
        phase = "R6 edge 64";
        idle(63);
        wr(8'hE7);
        idle(3);

        // special write in window keeps the normal chance
        phase = "R1";
        do_reset();
        phase = "R7 keeps chance";
        sp = 1'b1;
        idle(2);
        wr(8'h01);
        idle(1);
        sp = 1'b0;
        idle(1);
        wr(8'h26);
        idle(2);
        phase = "R9";
        step(1'b0, 1'b0, 8'h39, 8'h00);
        step(1'b0, 1'b1, 8'h3A, 8'h00);
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule